// File: doc/BRIEF.md
# HD Line CRC Generator and Inserter

This block protects each line of a high-definition component video stream with two 18-bit cyclic redundancy checks. The luma and chroma channels arrive as parallel 10-bit words, one word of each per clock when `in_valid` is high. Each channel has its own CRC engine, and each engine folds one 10-bit word per clock into its register. A line's CRC covers every word from the first word after the previous line's CRC slots up to and including the two line-number words. The end-of-active-video timing reference sits inside that span.

The upstream timing logic raises `eav_start` on the first word of the end-of-active-video sequence. The block counts words from that marker. The two words after the line-number words are the CRC slots. When insertion is enabled, the block writes the computed CRC into those slots as two 10-bit words. All other words pass through with one register of latency. A check mode compares the CRC words already present in the incoming slots against the locally computed values. It raises a sticky error flag per channel, which the host clears by writing a one.

Top module: `lcrc_line_inserter`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `luma_out`, `chroma_out` and `err_flags` are zero, and both CRC registers start at zero, so the first line's CRC begins from zero.
- R2: Each CRC register is 18 bits wide and is left-shifting. For each word, data bits 0 to 9 are fed in that order, one bit per step. At each step the feedback bit is register bit 17 XOR the data bit; the register shifts left by one, and when the feedback is 1 it is XORed with 0x00031 (x^18 + x^5 + x^4 + 1).
- R3: The luma CRC covers only `luma_in` and the chroma CRC covers only `chroma_in`. Each result is inserted only into its own channel.
- R4: Accumulation includes every valid word from the first word after the previous line's CRC slots through the second line-number word. The two CRC slot words are excluded. The register returns to zero after the second slot word.
- R5: When `eav_start` is high with a valid word, that word has offset 0. The four end-of-active-video words have offsets 0 to 3, the line-number words have offsets 4 and 5, and the CRC slots have offsets 6 (low) and 7 (high). Offsets count valid words only.
- R6: The low slot word carries CRC bits 8:0 in bits 8:0, and the high slot word carries CRC bits 17:9 in bits 8:0. In both words, bit 9 is the inverse of bit 8.
- R7: When `ins_en` is low, the slot words pass through unchanged.
- R8: Every valid input word appears at the outputs exactly one clock later, and `out_valid` follows `in_valid` by one clock. Non-slot words are never altered.
- R9: While `in_valid` is low, the CRC registers and word offsets do not advance, and `luma_out`/`chroma_out` hold their last values.
- R10: When `chk_en` is high, an incoming slot word that differs from the locally computed word sets `err_flags[0]` (luma) or `err_flags[1]` (chroma) one clock later. When `chk_en` is low, no flag is ever set.
- R11: Error flags are sticky. Writing a one to an `err_clr` bit clears the matching flag one clock later. A mismatch in the same clock as the clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input words valid this clock |
| eav_start | input | 1 | First word of the end-of-active-video sequence |
| luma_in | input | 10 | Luma word |
| chroma_in | input | 10 | Chroma word |
| ins_en | input | 1 | Write computed CRCs into the slots |
| chk_en | input | 1 | Compare incoming slot words with computed CRCs |
| err_clr | input | 2 | Write-one-to-clear for the error flags |
| out_valid | output | 1 | Output words valid |
| luma_out | output | 10 | Luma word after insertion |
| chroma_out | output | 10 | Chroma word after insertion |
| err_flags | output | 2 | Sticky mismatch flags, bit 0 luma, bit 1 chroma |

## Verification
The bench builds the block with its defaults: 10-bit words, an 18-bit CRC, a four-word timing reference and two line-number words. These settings place the CRC slots at fixed offsets 6 and 7 after the marker. Because the active part of a line can be as short as a handful of words, or even empty, the bench can run many complete lines. It covers insertion on and off, gaps in `in_valid` inside a line, a reset in the middle of a line, and clear/set collisions on the error flags, while computing each expected CRC bit by bit.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;

  // Per-word classification of the current input word
  typedef struct packed {
    logic acc;   // word is folded into the CRC
    logic lo;    // low CRC slot
    logic hi;    // high CRC slot
  } lcrc_phase_t;

  localparam int LANES = 2;  // 0 = luma, 1 = chroma

endpackage

// File: rtl/lcrc_timer.sv
module lcrc_timer
  import lcrc_pkg::*;
#(
  parameter int EAV_LEN = 4,
  parameter int LN_LEN  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        eav_start,
  output lcrc_phase_t phase
);

  localparam int SLOT_LO = EAV_LEN + LN_LEN;
  localparam int SLOT_HI = SLOT_LO + 1;
  localparam int PW      = $clog2(SLOT_HI + 1);

  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (in_valid) begin
      if (eav_start) begin
        pos_d = PW'(1);
      end else if (pos_q != '0) begin
        pos_d = (pos_q == PW'(SLOT_HI)) ? '0 : pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (in_valid) begin
      pos_q <= pos_d;
    end
  end

  always_comb begin
    phase.lo  = in_valid && !eav_start && (pos_q == PW'(SLOT_LO));
    phase.hi  = in_valid && !eav_start && (pos_q == PW'(SLOT_HI));
    phase.acc = in_valid && !phase.lo && !phase.hi;
  end

  // R5: offset counter never runs past the high slot
  a_r5_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PW'(SLOT_HI));

  // R5: the low slot is always followed, at the next valid word, by the high slot
  a_r5_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (phase.lo && !eav_start) |=> (pos_q == PW'(SLOT_HI)));

  // R9: offsets freeze while no word is valid
  a_r9_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q));

endmodule

// File: rtl/lcrc_lane.sv
module lcrc_lane
  import lcrc_pkg::*;
#(
  parameter int                    DW   = 10,
  parameter logic [2*(DW-1)-1:0]   POLY = 'h31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  lcrc_phase_t   phase,
  input  logic          ins_en,
  input  logic          chk_en,
  input  logic          err_clr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          err
);

  localparam int HALF = DW - 1;
  localparam int CW   = 2 * HALF;

  // Ten serial steps folded into one combinational update
  function automatic logic [CW-1:0] crc_fold(input logic [CW-1:0] c_in,
                                             input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic          fb;
    c = c_in;
    for (int i = 0; i < DW; i++) begin
      fb = c[CW-1] ^ d[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] slot_code(input logic [HALF-1:0] h);
    return {~h[HALF-1], h};
  endfunction

  logic [CW-1:0] crc_q, crc_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          err_q, err_d;
  logic [DW-1:0] slot_word;
  logic          in_slot, mism;

  assign in_slot   = phase.lo || phase.hi;
  assign slot_word = phase.lo ? slot_code(crc_q[HALF-1:0])
                              : slot_code(crc_q[CW-1:HALF]);
  assign mism      = chk_en && in_slot && (din != slot_word);

  always_comb begin
    crc_d = crc_q;
    if (phase.hi) begin
      crc_d = '0;
    end else if (phase.acc) begin
      crc_d = crc_fold(crc_q, din);
    end
  end

  always_comb begin
    dout_d = dout_q;
    if (in_valid) begin
      dout_d = (ins_en && in_slot) ? slot_word : din;
    end
  end

  always_comb begin
    err_d = err_q;
    if (mism) begin
      err_d = 1'b1;
    end else if (err_clr) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      dout_q <= '0;
    end else if (in_valid) begin
      crc_q  <= crc_d;
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign dout = dout_q;
  assign err  = err_q;

  // R4: register restarts from zero after the high slot
  a_r4_clear_after_slots: assert property (@(posedge clk) disable iff (!rst_n)
    phase.hi |=> (crc_q == '0));

  // R6: inserted slot words carry an inverted copy of bit 8 in bit 9
  a_r6_slot_format: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && in_slot) |=> (dout[DW-1] != dout[DW-2]));

  // R7: with insertion off every word passes untouched
  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ins_en) |=> (dout == $past(din)));

  // R9: nothing moves while no word is valid
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dout) && $stable(crc_q)));

  // R10: no flag is raised while checking is off
  a_r10_check_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !err) |=> !err);

  // R11: a set flag stays set until a clear arrives
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

endmodule

// File: rtl/lcrc_line_inserter.sv
module lcrc_line_inserter
  import lcrc_pkg::*;
#(
  parameter int                  DW      = 10,
  parameter int                  EAV_LEN = 4,
  parameter int                  LN_LEN  = 2,
  parameter logic [2*(DW-1)-1:0] POLY    = 'h31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          eav_start,
  input  logic [DW-1:0] luma_in,
  input  logic [DW-1:0] chroma_in,
  input  logic          ins_en,
  input  logic          chk_en,
  input  logic [1:0]    err_clr,
  output logic          out_valid,
  output logic [DW-1:0] luma_out,
  output logic [DW-1:0] chroma_out,
  output logic [1:0]    err_flags
);

  lcrc_phase_t   phase;
  logic [DW-1:0] din_a  [LANES];
  logic [DW-1:0] dout_a [LANES];
  logic          vld_q;

  assign din_a[0] = luma_in;
  assign din_a[1] = chroma_in;

  lcrc_timer #(
    .EAV_LEN (EAV_LEN),
    .LN_LEN  (LN_LEN)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .eav_start (eav_start),
    .phase     (phase)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lcrc_lane #(
      .DW   (DW),
      .POLY (POLY)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .phase    (phase),
      .ins_en   (ins_en),
      .chk_en   (chk_en),
      .err_clr  (err_clr[g]),
      .din      (din_a[g]),
      .dout     (dout_a[g]),
      .err      (err_flags[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  assign out_valid  = vld_q;
  assign luma_out   = dout_a[0];
  assign chroma_out = dout_a[1];

  // R8: output valid trails input valid by exactly one clock
  a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: a non-slot word leaves unaltered one clock later
  a_r8_plain_word: assert property (@(posedge clk) disable iff (!rst_n)
    phase.acc |=> (luma_out == $past(luma_in) && chroma_out == $past(chroma_in)));

endmodule

// File: tb/lcrc_line_inserter_tb.sv
module lcrc_line_inserter_tb;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       eav_start;
  logic [9:0] luma_in;
  logic [9:0] chroma_in;
  logic       ins_en;
  logic       chk_en;
  logic [1:0] err_clr;
  logic       out_valid;
  logic [9:0] luma_out;
  logic [9:0] chroma_out;
  logic [1:0] err_flags;

  int n_chk;
  int n_fail;
  logic [17:0] m_y, m_c;
  logic [9:0]  last_y, last_c;
  logic        done;

  lcrc_line_inserter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .eav_start  (eav_start),
    .luma_in    (luma_in),
    .chroma_in  (chroma_in),
    .ins_en     (ins_en),
    .chk_en     (chk_en),
    .err_clr    (err_clr),
    .out_valid  (out_valid),
    .luma_out   (luma_out),
    .chroma_out (chroma_out),
    .err_flags  (err_flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Table: {active words[7:0], seed[9:0], ins, chk, corrupt[1:0], expected flags[1:0]}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'd4,  10'h001, 1'b1, 1'b0, 2'b00, 2'b00},
    {8'd20, 10'h155, 1'b1, 1'b0, 2'b00, 2'b00},
    {8'd0,  10'h3FF, 1'b1, 1'b0, 2'b00, 2'b00},
    {8'd12, 10'h2AA, 1'b0, 1'b0, 2'b00, 2'b00},
    {8'd9,  10'h0F0, 1'b1, 1'b1, 2'b00, 2'b00},
    {8'd7,  10'h333, 1'b1, 1'b1, 2'b01, 2'b01},
    {8'd15, 10'h0AB, 1'b0, 1'b1, 2'b10, 2'b10},
    {8'd5,  10'h111, 1'b1, 1'b0, 2'b11, 2'b00}
  };

  function automatic logic [17:0] ref_step(input logic [17:0] c_in, input logic [9:0] d);
    logic [17:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 10; i++) begin
      fb = c[17] ^ d[i];
      c  = {c[16:0], 1'b0};
      if (fb) c = c ^ 18'h00031;
    end
    return c;
  endfunction

  function automatic logic [9:0] ref_word(input logic [8:0] h);
    return {~h[8], h};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Drive one clock of input, then sample after the edge
  task automatic push(input logic v, input logic eav, input logic [9:0] y, input logic [9:0] c,
                      input logic [9:0] ey, input logic [9:0] ec, input logic [1:0] clr,
                      input string tag);
    in_valid  = v;
    eav_start = eav;
    luma_in   = y;
    chroma_in = c;
    err_clr   = clr;
    @(posedge clk);
    #5;
    err_clr   = 2'b00;
    if (v) begin
      check({31'd0, out_valid}, 32'd1, {tag, " R8 out_valid"});
      check({22'd0, luma_out}, {22'd0, ey}, {tag, " luma"});
      check({22'd0, chroma_out}, {22'd0, ec}, {tag, " chroma"});
      last_y = ey;
      last_c = ec;
    end else begin
      check({31'd0, out_valid}, 32'd0, "R8 R9 out_valid idle");
      check({22'd0, luma_out}, {22'd0, last_y}, "R9 luma held");
      check({22'd0, chroma_out}, {22'd0, last_c}, "R9 chroma held");
    end
  endtask

  task automatic acc_word(input logic eav, input logic [9:0] y, input logic [9:0] c, input string tag);
    push(1'b1, eav, y, c, y, c, 2'b00, tag);
    m_y = ref_step(m_y, y);
    m_c = ref_step(m_c, c);
  endtask

  task automatic send_line(input int n, input logic [9:0] seed, input logic ins,
                           input logic chk, input logic [1:0] cor, input logic gap,
                           input logic [1:0] slot_clr);
    logic [9:0] y, c, wy, wc, fy, fc;
    ins_en = ins;
    chk_en = chk;
    for (int k = 0; k < n; k++) begin
      y = seed + 10'(k * 37);
      c = seed ^ 10'(k * 91);
      acc_word(1'b0, y, c, "R4 R8 active word");
      if (gap && k == 0) begin
        push(1'b0, 1'b0, 10'h3A5, 10'h15A, 10'h0, 10'h0, 2'b00, "R9");
        push(1'b0, 1'b1, 10'h0F3, 10'h2C4, 10'h0, 10'h0, 2'b00, "R9");
      end
    end
    acc_word(1'b1, 10'h3FF, 10'h3FF, "R5 timing ref 0");
    acc_word(1'b0, 10'h000, 10'h000, "R5 timing ref 1");
    acc_word(1'b0, 10'h000, 10'h000, "R5 timing ref 2");
    acc_word(1'b0, 10'h274, 10'h274, "R5 timing ref 3");
    acc_word(1'b0, {~seed[6], seed[6:0], 2'b00}, {~seed[6], seed[6:0], 2'b00}, "R4 line number 0");
    acc_word(1'b0, 10'h200, 10'h200, "R4 line number 1");
    // low slot
    wy = ref_word(m_y[8:0]);
    wc = ref_word(m_c[8:0]);
    fy = chk ? (wy ^ {9'd0, cor[0]}) : (wy ^ 10'h155);
    fc = chk ? (wc ^ {9'd0, cor[1]}) : (wc ^ 10'h0AA);
    push(1'b1, 1'b0, fy, fc, ins ? wy : fy, ins ? wc : fc, slot_clr,
         ins ? "R2 R3 R6 low slot" : "R7 low slot");
    // high slot
    wy = ref_word(m_y[17:9]);
    wc = ref_word(m_c[17:9]);
    fy = chk ? wy : (wy ^ 10'h0C3);
    fc = chk ? wc : (wc ^ 10'h30C);
    push(1'b1, 1'b0, fy, fc, ins ? wy : fy, ins ? wc : fc, 2'b00,
         ins ? "R2 R3 R6 high slot" : "R7 high slot");
    m_y = '0;
    m_c = '0;
  endtask

  task automatic do_reset();
    in_valid  = 1'b0;
    eav_start = 1'b0;
    luma_in   = '0;
    chroma_in = '0;
    err_clr   = '0;
    rst_n     = 1'b0;
    #5;
    check({31'd0, out_valid}, 32'd0, "R1 out_valid in reset");
    check({22'd0, luma_out}, 32'd0, "R1 luma_out in reset");
    check({22'd0, chroma_out}, 32'd0, "R1 chroma_out in reset");
    check({30'd0, err_flags}, 32'd0, "R1 err_flags in reset");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_y = '0;
    m_c = '0;
    last_y = '0;
    last_c = '0;
  endtask

  initial begin
    done = 1'b0;
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
          $finish;
        end
      end
    join_none
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    ins_en = 1'b1;
    chk_en = 1'b0;
    do_reset();
    @(posedge clk);
    #5;
    check({31'd0, out_valid}, 32'd0, "R1 out_valid after release");
    check({30'd0, err_flags}, 32'd0, "R1 err_flags after release");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      send_line(int'(VEC[i][23:16]), VEC[i][15:6], VEC[i][5], VEC[i][4], VEC[i][3:2],
                i == 1, 2'b00);
      check({30'd0, err_flags}, {30'd0, VEC[i][1:0]}, "R10 flags after line");
      push(1'b0, 1'b0, 10'h0, 10'h0, 10'h0, 10'h0, 2'b11, "R11");
      check({30'd0, err_flags}, 32'd0, "R11 flags after clear");
    end

    // Same-clock clear and mismatch: set wins
    send_line(6, 10'h2F0, 1'b1, 1'b1, 2'b11, 1'b0, 2'b11);
    check({30'd0, err_flags}, 32'd3, "R11 set wins over clear");
    push(1'b0, 1'b0, 10'h0, 10'h0, 10'h0, 10'h0, 2'b10, "R11");
    check({30'd0, err_flags}, 32'd1, "R11 clear chroma only");
    push(1'b0, 1'b0, 10'h0, 10'h0, 10'h0, 10'h0, 2'b01, "R11");
    check({30'd0, err_flags}, 32'd0, "R11 clear luma");

    // Reset in the middle of a line, then a line from zero
    ins_en = 1'b1;
    chk_en = 1'b0;
    acc_word(1'b0, 10'h123, 10'h321, "R8 pre-reset word");
    acc_word(1'b0, 10'h0FF, 10'h1EE, "R8 pre-reset word");
    do_reset();
    send_line(3, 10'h045, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00);

    // Gap inside the line with check mode on
    send_line(10, 10'h1C7, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00);
    check({30'd0, err_flags}, 32'd0, "R9 R10 no flag after gap line");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule